// File: doc/BRIEF.md
# Serial Receive/Transmit Line Status Tracker

This block keeps the eight-bit line status word of a classic serial port. Every received byte is pushed together with three error tags (parity, framing, break) into a receive queue. The tags stay with their byte, and the status word shows the tags of the byte at the head of the queue. In queue mode a sticky summary bit reports that some tagged byte is waiting anywhere in the queue. On the transmit side the block counts the characters waiting in the holding stage. From that count and a shift-register busy input it derives the holding-empty and transmitter-empty flags.

In single-byte mode the receive and transmit holding stages each hold one character. In queue mode each holds up to its configured depth. Reading the status word clears the overrun flag and the head's error tags. When a line-status interrupt is enabled, an interrupt request is raised while the overrun bit or any of the three error bits is set. Mode changes are expected only together with reset.

Top module: `uart_lsr_tracker`

## Requirements
- R1: Bit 0 (data ready) is 1 exactly when the receive queue holds at least one byte. The byte at the head appears on `rx_head_data`, and bytes leave in the order they were accepted.
- R2: A push that arrives when the receive queue is at capacity (1 in single-byte mode, RX_DEPTH in queue mode) and no pop occurs in the same cycle is dropped and sets bit 1 (overrun). A status read clears bit 1 unless a new overrun occurs in that same cycle.
- R3: Bits 2, 3 and 4 show the parity, framing and break tags of the byte at the head of the queue. Tags of the other bytes do not show there.
- R4: A status read hides the head's tags: bits 2 to 4 read 0 until the head byte is popped. A read while the queue is empty has no effect on the next byte.
- R5: Bit 5 (holding empty) is 1 exactly when no transmit character is waiting. A CPU write adds one character, up to a capacity of 1 in single-byte mode or TX_DEPTH in queue mode, with excess writes ignored. A move into the shift register removes one.
- R6: Bit 6 (transmitter empty) is 1 only when bit 5 is 1 and the shift register is idle.
- R7: Bit 7 reads 0 in single-byte mode.
- R8: In queue mode, bit 7 becomes 1 once any tagged byte is in the queue. It stays 1 until a status read that happens when no tagged byte remains after that cycle.
- R9: The interrupt request is 1 exactly when the line-status interrupt enable is 1 and any of bits 1 to 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 selects queue mode, 0 single-byte mode |
| ls_irq_en | input | 1 | Line-status interrupt enable |
| rx_push | input | 1 | A received byte is offered |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity tag of the offered byte |
| rx_frm_err | input | 1 | Framing tag of the offered byte |
| rx_brk | input | 1 | Break tag of the offered byte |
| rx_pop | input | 1 | CPU takes the head byte |
| rx_head_data | output | 8 | Byte at the head of the receive queue |
| lsr_rd | input | 1 | CPU reads the status word |
| tx_wr | input | 1 | CPU writes a transmit character |
| tx_load | input | 1 | A character moves into the shift register |
| tsr_busy | input | 1 | Shift register holds a character |
| lsr | output | 8 | Line status word |
| ls_irq | output | 1 | Line-status interrupt request |

## Verification
The assertions take for granted that `fifo_mode` stays fixed between resets. They also assume every input is a defined 0 or 1 after reset. The bench asserts reset before each mode change. Within a mode it drives random pushes, pops, reads, writes and loads on every cycle, all of them legal, since pops on an empty queue, excess writes and over-capacity pushes are defined behaviour. It then adds directed runs that fill the queue to overrun and that move a tagged byte out before or after a read.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;

  function automatic logic tag_any(input rx_tag_t t);
    return t.brk | t.frm | t.par;
  endfunction

  // Occupancy update: add one, remove one, or both.
  function automatic int unsigned occ_next(input int unsigned occ,
                                           input logic add, input logic sub);
    return occ + (add ? 1 : 0) - (sub ? 1 : 0);
  endfunction
endpackage

// File: rtl/lsr_rx_queue.sv
module lsr_rx_queue
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  rx_tag_t       push_tag,
  input  logic          pop,
  output logic [7:0]    head_data,
  output rx_tag_t       head_tag,
  output logic          not_empty,
  output logic          push_ok,
  output logic          push_drop,
  output logic          pop_ok,
  output logic [CW-1:0] occ
);
  logic [7:0]    dmem [DEPTH];
  rx_tag_t       tmem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;

  assign cap       = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign not_empty = (occ != '0);
  assign pop_ok    = pop && not_empty;
  assign push_ok   = push && ((occ < cap) || pop_ok);
  assign push_drop = push && !push_ok;
  assign head_data = dmem[rptr];
  assign head_tag  = tmem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      dmem[wptr] <= push_data;
      tmem[wptr] <= push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      occ <= CW'(occ_next(int'(occ), push_ok, pop_ok));
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= cap);
  p_drop_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> $stable(occ));
endmodule

// File: rtl/lsr_err_summary.sv
module lsr_err_summary
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          push_ok,
  input  rx_tag_t       push_tag,
  input  logic          pop_ok,
  input  rx_tag_t       head_tag,
  input  logic [CW-1:0] occ,
  input  logic          lsr_rd,
  output logic          summary
);
  logic [CW-1:0] err_cnt, err_cnt_nxt;
  logic          sticky;
  logic          tagged_in, tagged_out;

  assign tagged_in   = push_ok && tag_any(push_tag);
  assign tagged_out  = pop_ok && tag_any(head_tag);
  assign err_cnt_nxt = CW'(occ_next(int'(err_cnt), tagged_in, tagged_out));
  assign summary     = fifo_mode && sticky;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt <= '0;
      sticky  <= 1'b0;
    end else begin
      err_cnt <= err_cnt_nxt;
      sticky  <= (sticky && !lsr_rd) || (err_cnt_nxt != '0);
    end
  end

  p_err_le_occ_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= occ);
  p_read_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode && lsr_rd && err_cnt_nxt != '0) |=> summary);
  p_zero_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !summary);
endmodule

// File: rtl/lsr_tx_track.sv
module lsr_tx_track
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic wr,
  input  logic load,
  input  logic tsr_busy,
  output logic hold_empty,
  output logic tx_empty
);
  logic [CW-1:0] cnt, cap;
  logic          load_ok, wr_ok;

  assign cap        = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign load_ok    = load && (cnt != '0);
  assign wr_ok      = wr && ((cnt < cap) || load_ok);
  assign hold_empty = (cnt == '0);
  assign tx_empty   = hold_empty && !tsr_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CW'(occ_next(int'(cnt), wr_ok, load_ok));
  end

  p_write_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !load) |=> !hold_empty);
  p_temt_needs_thre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);
endmodule

// File: rtl/uart_lsr_tracker.sv
module uart_lsr_tracker
  import uart_lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_mode,
  input  logic       ls_irq_en,
  input  logic       rx_push,
  input  logic [7:0] rx_byte,
  input  logic       rx_par_err,
  input  logic       rx_frm_err,
  input  logic       rx_brk,
  input  logic       rx_pop,
  output logic [7:0] rx_head_data,
  input  logic       lsr_rd,
  input  logic       tx_wr,
  input  logic       tx_load,
  input  logic       tsr_busy,
  output logic [7:0] lsr,
  output logic       ls_irq
);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  rx_tag_t        in_tag, head_tag, shown_tag;
  logic           not_empty, push_ok, push_drop, pop_ok;
  logic [RCW-1:0] occ;
  logic           overrun, head_seen, summary;
  logic           hold_empty, tx_empty;

  assign in_tag = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err};

  lsr_rx_queue #(.DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .push(rx_push), .push_data(rx_byte), .push_tag(in_tag), .pop(rx_pop),
    .head_data(rx_head_data), .head_tag(head_tag), .not_empty(not_empty),
    .push_ok(push_ok), .push_drop(push_drop), .pop_ok(pop_ok), .occ(occ)
  );

  lsr_err_summary #(.DEPTH(RX_DEPTH)) u_sum (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .push_ok(push_ok), .push_tag(in_tag), .pop_ok(pop_ok),
    .head_tag(head_tag), .occ(occ), .lsr_rd(lsr_rd), .summary(summary)
  );

  lsr_tx_track #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .wr(tx_wr), .load(tx_load), .tsr_busy(tsr_busy),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  // Overrun is sticky until read; head_seen hides head tags once read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun   <= 1'b0;
      head_seen <= 1'b0;
    end else begin
      if (push_drop)   overrun <= 1'b1;
      else if (lsr_rd) overrun <= 1'b0;
      if (pop_ok)                   head_seen <= 1'b0;
      else if (lsr_rd && not_empty) head_seen <= 1'b1;
    end
  end

  assign shown_tag = (not_empty && !head_seen) ? head_tag : '0;
  assign lsr = {summary, tx_empty, hold_empty, shown_tag.brk, shown_tag.frm,
                shown_tag.par, overrun, not_empty};
  assign ls_irq = ls_irq_en && (|lsr[4:1]);

  p_overrun_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> lsr[1]);
  p_read_hides_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && not_empty && !pop_ok) |=> (lsr[4:2] == 3'b000));
  p_irq_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_irq) |-> ls_irq_en);
  p_dr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rx_pop) |=> lsr[0]);
endmodule

// File: tb/uart_lsr_tracker_bench.sv
module uart_lsr_tracker_bench;
  localparam int RXD = 16;
  localparam int TXD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_mode = 1'b0, ls_irq_en = 1'b0;
  logic rx_push = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, rx_brk = 1'b0;
  logic rx_pop = 1'b0, lsr_rd = 1'b0, tx_wr = 1'b0, tx_load = 1'b0, tsr_busy = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic [7:0] rx_head_data, lsr;
  logic       ls_irq;

  int checks = 0, errors = 0;

  // model state
  logic [10:0] q[$];  // {brk,frm,par,data}
  bit m_ovr, m_seen, m_sticky;
  int m_txc;

  always #2 clk = ~clk;

  uart_lsr_tracker #(.RX_DEPTH(RXD), .TX_DEPTH(TXD)) u_uart_lsr_tracker (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ls_irq_en(ls_irq_en),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rx_pop(rx_pop),
    .rx_head_data(rx_head_data), .lsr_rd(lsr_rd), .tx_wr(tx_wr),
    .tx_load(tx_load), .tsr_busy(tsr_busy), .lsr(lsr), .ls_irq(ls_irq)
  );

  function automatic int err_entries();
    int n = 0;
    foreach (q[i]) if (q[i][10:8] != 3'b000) n++;
    return n;
  endfunction

  function automatic logic [7:0] exp_lsr();
    logic [2:0] tg;
    bit thre;
    tg   = (q.size() != 0 && !m_seen) ? q[0][10:8] : 3'b000;
    thre = (m_txc == 0);
    return {fifo_mode && m_sticky, thre && !tsr_busy, thre, tg, m_ovr, q.size() != 0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] e;
    e = exp_lsr();
    chk("R1 data ready", lsr[0], e[0]);
    chk("R2 overrun", lsr[1], e[1]);
    chk("R3 R4 head tags", lsr[4:2], e[4:2]);
    chk("R5 holding empty", lsr[5], e[5]);
    chk("R6 transmitter empty", lsr[6], e[6]);
    chk(fifo_mode ? "R8 summary" : "R7 summary zero", lsr[7], e[7]);
    chk("R9 irq", ls_irq, ls_irq_en && (|e[4:1]));
    if (q.size() != 0) chk("R1 head data", rx_head_data, q[0][7:0]);
  endtask

  // model update for the inputs applied at the coming edge
  task automatic model_step();
    bit pop_ok, push_ok;
    int cap, tcap;
    bit lok, wok;
    cap    = fifo_mode ? RXD : 1;
    tcap   = fifo_mode ? TXD : 1;
    pop_ok = rx_pop && q.size() != 0;
    push_ok = rx_push && (q.size() < cap || pop_ok);
    if (rx_push && !push_ok) m_ovr = 1;
    else if (lsr_rd) m_ovr = 0;
    if (pop_ok) m_seen = 0;
    else if (lsr_rd && q.size() != 0) m_seen = 1;
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back({rx_brk, rx_frm_err, rx_par_err, rx_byte});
    m_sticky = (m_sticky && !lsr_rd) || (err_entries() != 0);
    lok = tx_load && m_txc != 0;
    wok = tx_wr && (m_txc < tcap || lok);
    m_txc = m_txc + int'(wok) - int'(lok);
  endtask

  // compare current state, then apply new inputs and advance model
  task automatic cyc(input bit push, input logic [7:0] d, input logic [2:0] tg,
                     input bit pop, input bit rd, input bit wr, input bit ld,
                     input bit busy);
    @(negedge clk);
    compare_all();
    rx_push = push; rx_byte = d; {rx_brk, rx_frm_err, rx_par_err} = tg;
    rx_pop = pop; lsr_rd = rd; tx_wr = wr; tx_load = ld; tsr_busy = busy;
    model_step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 3'b000, 0, 0, 0, 0, tsr_busy);
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0; fifo_mode = mode;
    {rx_push, rx_pop, lsr_rd, tx_wr, tx_load, tsr_busy} = '0;
    q.delete(); m_ovr = 0; m_seen = 0; m_sticky = 0; m_txc = 0;
    @(negedge clk);
    chk("R1 reset state", lsr, {1'b0, 1'b1, 1'b1, 5'b0});
    rst_n = 1'b1;
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [2:0] tg;
      tg = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      cyc($urandom_range(0, 2) == 0, 8'($urandom), tg,
          $urandom_range(0, 3) == 0, $urandom_range(0, 5) == 0,
          $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
          $urandom_range(0, 1) == 1);
      if (i % 97 == 0) ls_irq_en = ~ls_irq_en;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    // single-byte mode
    do_reset(1'b0);
    ls_irq_en = 1'b1;
    cyc(1, 8'hA5, 3'b010, 0, 0, 0, 0, 0);   // framing tag on only byte (R3)
    cyc(1, 8'h11, 3'b000, 0, 0, 0, 0, 0);   // full: overrun (R2)
    idle(1);
    cyc(0, 8'h00, 3'b000, 0, 1, 0, 0, 0);   // read clears R2, hides R4
    idle(1);
    cyc(0, 8'h00, 3'b000, 1, 0, 1, 0, 0);   // pop; write tx (R5)
    cyc(0, 8'h00, 3'b000, 0, 0, 1, 0, 1);   // excess write ignored
    cyc(0, 8'h00, 3'b000, 0, 0, 0, 1, 1);   // load: holding empty, busy (R6)
    idle(2);
    random_run(3000);

    // queue mode
    do_reset(1'b1);
    ls_irq_en = 1'b1;
    cyc(1, 8'h01, 3'b000, 0, 0, 0, 0, 0);
    cyc(1, 8'h02, 3'b001, 0, 0, 0, 0, 0);   // tagged byte behind clean head (R3, R8)
    cyc(1, 8'h03, 3'b100, 0, 0, 0, 0, 0);
    cyc(0, 8'h00, 3'b000, 1, 0, 0, 0, 0);   // head now parity-tagged
    cyc(0, 8'h00, 3'b000, 0, 1, 0, 0, 0);   // read: summary stays, tags hidden
    cyc(0, 8'h00, 3'b000, 1, 0, 0, 0, 0);   // break head appears
    cyc(0, 8'h00, 3'b000, 1, 0, 0, 0, 0);   // empty, summary still sticky
    idle(1);
    cyc(0, 8'h00, 3'b000, 0, 1, 0, 0, 0);   // read clears summary (R8)
    cyc(0, 8'h00, 3'b000, 0, 1, 0, 0, 0);   // read on empty queue (R4)
    cyc(1, 8'h44, 3'b100, 0, 0, 0, 0, 0);   // new head shows tag
    for (int i = 0; i < RXD + 2; i++)
      cyc(1, 8'(i), 3'b000, 0, 0, 1, 0, 0); // fill to overrun, fill tx
    idle(1);
    for (int i = 0; i < RXD + 1; i++)
      cyc(0, 8'h00, 3'b000, 1, i == 3, 0, 1, 0); // drain in order (R1)
    idle(2);
    random_run(6000);
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule